// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the bus-facing register bank of a simple byte serial port. A host reaches it through single-cycle 32-bit reads and writes at byte addresses inside a 0x3C-byte window. Received bytes arrive on a valid/ready stream and are held in a 16-entry circular FIFO. Two status words expose that FIFO. One only peeks at the oldest byte. The other returns the oldest byte and removes it in the same access.

Writing the output data register sends its low byte out as a one-cycle transmit strobe. The write also raises two interrupt causes and arms a pending-transmit flag. The next acknowledge write is prevented from clearing the transmit-done cause (raw bit 0), and it disarms the flag. A raw cause register, a mask and their AND drive a single level interrupt. The transmitter is treated as permanently ready and idle. Serialization, baud timing, DMA and line errors belong to other blocks.

Receive stream rules: a byte transfers on a cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` is high exactly while the receiver is enabled, so the source sees back-pressure only from the enable. A transferred byte that meets a full FIFO is dropped. The transmit stream has no back-pressure: `tx_valid` is a strobe and the sink must take the byte in that cycle.

Top module: `sport_regfile`

## Requirements
- R1: After reset, word 0x08 (receive control) reads 0x00010000, word 0x2C (mask) reads 0, the FIFO is empty, `irq` is 0 and `rx_ready` is 0.
- R2: Reads of words 0x20 and 0x24 always have bit 24 and bit 22 set. Bit 16 is 1 exactly when the FIFO holds a byte. Bits 7:0 carry the oldest byte, or 0 when the FIFO is empty. All other bits are 0.
- R3: A read of 0x20 removes the oldest byte when the FIFO is non-empty. A read of 0x24 leaves the FIFO unchanged.
- R4: The FIFO keeps up to 16 bytes in arrival order. A byte transferred while 16 are held is discarded.
- R5: `rx_ready` equals bit 3 of receive control. A byte presented while `rx_ready` is 0 is not stored.
- R6: A write to word 0x1C makes `tx_valid` high for exactly the next cycle, with `tx_data` equal to the written bits 7:0. The write sets raw bits 0 and 1, arms the pending-transmit flag, and the written word reads back from 0x1C.
- R7: A write to 0x30 clears every raw bit that is 1 in the written value. When the pending-transmit flag is armed, bit 0 of the value is first forced to 0 and the flag is disarmed. Word 0x30 reads back the adjusted value.
- R8: Raw bit 3 (word 0x34) always equals FIFO non-empty, whatever is written or acknowledged.
- R9: Word 0x38 reads raw AND mask. `irq` is high exactly when that value is non-zero. Both reflect a write, push or pop from the cycle after it.
- R10: Words 0x00, 0x04, 0x08, 0x2C and 0x34 read back the last value written (bit 3 of 0x34 excepted). Writes to 0x20, 0x24 and 0x38 have no effect. Unmapped words, and any access with address bits 1:0 non-zero, read 0 and change nothing.
- R11: A byte transfer and a popping read in the same cycle leave the count unchanged and keep byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receiver enabled, transfer accepted |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt, any masked cause set |

## Verification
Read data is combinational, so each read is compared in the same cycle it is issued, just before the clock edge. That value reflects the state left by earlier cycles, not the effects of the current one. Pushes, pops, register writes, the interrupt level and `rx_ready` all settle at one clock edge. The bench applies each stimulus to its queue-based model at that edge and compares `irq`, `rx_ready` and the transmit strobe at the following falling edge. The transmit strobe is due exactly one edge after the output write, and the model expects it in that single cycle only.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;

  // Word index = byte address bits 5:2
  typedef enum logic [3:0] {
    W_TXCTL  = 4'h0,
    W_TXDMA  = 4'h1,
    W_RXCTL  = 4'h2,
    W_DOUT   = 4'h7,
    W_STPOP  = 4'h8,
    W_STPEEK = 4'h9,
    W_MASK   = 4'hB,
    W_ACK    = 4'hC,
    W_RAW    = 4'hD,
    W_MSKD   = 4'hE
  } word_e;

  localparam int BIT_HAVE  = 16;
  localparam int BIT_TIDLE = 22;
  localparam int BIT_TRDY  = 24;
  localparam int BIT_RXEN  = 3;
  localparam logic [DATA_W-1:0] RXCTL_RST = 32'h0001_0000;
endpackage

// File: rtl/sport_rx_fifo.sv
module sport_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          nonempty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, do_push, do_pop;

  assign full     = (count == CW'(DEPTH));
  assign nonempty = (count != '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && nonempty;
  assign head     = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sport_irq_ctrl.sv
module sport_irq_ctrl
  import sport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dout_wr,
  input  logic              ack_wr,
  input  logic              raw_wr,
  input  logic              mask_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rx_nonempty,
  output logic [DATA_W-1:0] raw_view,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] ack_q,
  output logic [DATA_W-1:0] masked,
  output logic              irq
);
  logic [DATA_W-1:0] raw_q, ack_val;
  logic              pend_q;

  // Pending transmit shields the transmit-done cause from one acknowledge
  always_comb begin
    ack_val = wdata;
    if (pend_q) ack_val[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
      ack_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (dout_wr) begin
        raw_q  <= raw_q | DATA_W'(3);
        pend_q <= 1'b1;
      end else if (ack_wr) begin
        raw_q  <= raw_q & ~ack_val;
        ack_q  <= ack_val;
        pend_q <= 1'b0;
      end else if (raw_wr) begin
        raw_q  <= wdata;
      end
      if (mask_wr) mask_q <= wdata;
    end
  end

  always_comb begin
    raw_view    = raw_q;
    raw_view[3] = rx_nonempty;
  end

  assign masked = raw_view & mask_q;
  assign irq    = |masked;
endmodule

// File: rtl/sport_regfile.sv
module sport_regfile
  import sport_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              irq
);
  logic [3:0]        wsel;
  logic              acc_ok, rd_en, wr_en;
  logic [DATA_W-1:0] txctl_q, txdma_q, rxctl_q, dout_q;
  logic [DATA_W-1:0] raw_view, mask_q, ack_q, masked, status;
  logic [BYTE_W-1:0] head;
  logic [CW-1:0]     rx_count;
  logic              rx_nonempty, pop_rd;

  assign wsel   = bus_addr[ADDR_W-1:2];
  assign acc_ok = bus_sel && (bus_addr[1:0] == 2'b00);
  assign rd_en  = acc_ok && !bus_we;
  assign wr_en  = acc_ok && bus_we;
  assign pop_rd = rd_en && (wsel == W_STPOP);

  assign rx_ready = rxctl_q[BIT_RXEN];

  sport_rx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) fifo_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (rx_valid && rx_ready),
    .din      (rx_data),
    .pop      (pop_rd),
    .head     (head),
    .count    (rx_count),
    .nonempty (rx_nonempty)
  );

  sport_irq_ctrl irq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .dout_wr     (wr_en && (wsel == W_DOUT)),
    .ack_wr      (wr_en && (wsel == W_ACK)),
    .raw_wr      (wr_en && (wsel == W_RAW)),
    .mask_wr     (wr_en && (wsel == W_MASK)),
    .wdata       (bus_wdata),
    .rx_nonempty (rx_nonempty),
    .raw_view    (raw_view),
    .mask_q      (mask_q),
    .ack_q       (ack_q),
    .masked      (masked),
    .irq         (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txctl_q  <= '0;
      txdma_q  <= '0;
      rxctl_q  <= RXCTL_RST;
      dout_q   <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= wr_en && (wsel == W_DOUT);
      if (wr_en) begin
        case (wsel)
          W_TXCTL: txctl_q <= bus_wdata;
          W_TXDMA: txdma_q <= bus_wdata;
          W_RXCTL: rxctl_q <= bus_wdata;
          W_DOUT: begin
            dout_q  <= bus_wdata;
            tx_data <= bus_wdata[BYTE_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    status            = '0;
    status[BIT_TRDY]  = 1'b1;
    status[BIT_TIDLE] = 1'b1;
    status[BIT_HAVE]  = rx_nonempty;
    status[BYTE_W-1:0] = rx_nonempty ? head : '0;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (wsel)
        W_TXCTL:  bus_rdata = txctl_q;
        W_TXDMA:  bus_rdata = txdma_q;
        W_RXCTL:  bus_rdata = rxctl_q;
        W_DOUT:   bus_rdata = dout_q;
        W_STPOP:  bus_rdata = status;
        W_STPEEK: bus_rdata = status;
        W_MASK:   bus_rdata = mask_q;
        W_ACK:    bus_rdata = ack_q;
        W_RAW:    bus_rdata = raw_view;
        W_MSKD:   bus_rdata = masked;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sport_checker.sv
module sport_checker #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [5:0]    bus_addr,
  input logic [7:0]    wdata_lo,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          tx_valid,
  input logic [7:0]    tx_data,
  input logic          irq,
  input logic [CW-1:0] fifo_count,
  input logic [31:0]   raw_view,
  input logic [31:0]   mask_q
);
  logic rd_pop, rd_peek, wr_dout;
  assign rd_pop  = bus_sel && !bus_we && bus_addr == 6'h20;
  assign rd_peek = bus_sel && !bus_we && bus_addr == 6'h24;
  assign wr_dout = bus_sel && bus_we && bus_addr == 6'h1C;

  AST_TX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dout |=> (tx_valid && tx_data == $past(wdata_lo))); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH)); // R4
  AST_GATED_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !rd_pop) |=> fifo_count == $past(fifo_count)); // R5
  AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_peek && !rx_valid) |=> $stable(fifo_count)); // R3
  AST_POP_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && fifo_count != '0 && !rx_valid) |=> fifo_count == CW'($past(fifo_count) - 1'b1)); // R3
  AST_RX_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count != '0) |-> raw_view[3]); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0)); // R9
endmodule

bind sport_regfile sport_checker #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .wdata_lo   (bus_wdata[7:0]),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .tx_valid   (tx_valid),
  .tx_data    (tx_data),
  .irq        (irq),
  .fifo_count (rx_count),
  .raw_view   (raw_view),
  .mask_q     (mask_q)
);

// File: tb/sport_regfile_tb_top.sv
module sport_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 0, bus_we = 0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_data;

  always #10 clk = ~clk;

  sport_regfile dut_i (.*);

  // Reference model
  logic [7:0]  q[$];
  logic [31:0] raw_m = 0, mask_m = 0, ack_m = 0, txc_m = 0, dma_m = 0;
  logic [31:0] rxc_m = 32'h0001_0000, dout_m = 0;
  bit          pend_m = 0, txv_m = 0;
  logic [7:0]  txd_m = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rawv();
    logic [31:0] r = raw_m;
    r[3] = (q.size() != 0);
    return r;
  endfunction

  function automatic logic [31:0] stat();
    logic [31:0] s = 32'h0140_0000;
    if (q.size() != 0) s = s | 32'h0001_0000 | {24'h0, q[0]};
    return s;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    if (a[1:0] != 0) return 0;
    case (a[5:2])
      4'h0: return txc_m;
      4'h1: return dma_m;
      4'h2: return rxc_m;
      4'h7: return dout_m;
      4'h8, 4'h9: return stat();
      4'hB: return mask_m;
      4'hC: return ack_m;
      4'hD: return rawv();
      4'hE: return rawv() & mask_m;
      default: return 0;
    endcase
  endfunction

  // One cycle, entered just after a falling edge
  task automatic cyc(input string tag, input bit sel, input bit we, input logic [5:0] a,
                     input logic [31:0] d, input bit rv, input logic [7:0] rd);
    bit rd_acc, wr_acc, do_pop, do_push;
    logic [31:0] v;
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d;
    rx_valid = rv; rx_data = rd;
    #5;
    rd_acc = sel && !we && a[1:0] == 0;
    wr_acc = sel && we && a[1:0] == 0;
    if (rd_acc) chk(tag, bus_rdata, exp_rd(a));
    do_pop  = rd_acc && a[5:2] == 4'h8 && q.size() > 0;
    do_push = rv && rxc_m[3] && q.size() < 16;
    if (do_pop) void'(q.pop_front());
    if (do_push) q.push_back(rd);
    txv_m = 0;
    if (wr_acc) begin
      case (a[5:2])
        4'h0: txc_m = d;
        4'h1: dma_m = d;
        4'h2: rxc_m = d;
        4'h7: begin dout_m = d; raw_m = raw_m | 3; pend_m = 1; txv_m = 1; txd_m = d[7:0]; end
        4'hB: mask_m = d;
        4'hC: begin v = d; if (pend_m) v[0] = 1'b0; pend_m = 0; ack_m = v; raw_m = raw_m & ~v; end
        4'hD: raw_m = d;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; rx_valid = 0;
    chk("R9 irq", {31'h0, irq}, {31'h0, |(rawv() & mask_m)});
    chk("R5 rx_ready", {31'h0, rx_ready}, {31'h0, rxc_m[3]});
    chk("R6 tx_valid", {31'h0, tx_valid}, {31'h0, txv_m});
    if (txv_m) chk("R6 tx_data", {24'h0, tx_data}, {24'h0, txd_m});
  endtask

  task automatic rd(input string tag, input logic [5:0] a);
    cyc(tag, 1, 0, a, 0, 0, 0);
  endtask
  task automatic wr(input string tag, input logic [5:0] a, input logic [31:0] d);
    cyc(tag, 1, 1, a, d, 0, 0);
  endtask
  task automatic rx(input logic [7:0] b);
    cyc("R4 push", 0, 0, 0, 0, 1, b);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd("R1 rxctl", 6'h08);
    rd("R1 mask", 6'h2C);
    rd("R2 status empty", 6'h24);
    rd("R1 raw", 6'h34);
    // R5 disabled receiver drops bytes
    rx(8'h11);
    rd("R5 nothing stored", 6'h24);
    // R10 readback, enable receiver
    wr("R10", 6'h00, 32'hDEAD_BEEF);
    wr("R10", 6'h04, 32'h0000_0005);
    wr("R10", 6'h08, 32'h0000_0008);
    rd("R10 txctl", 6'h00);
    rd("R10 txdma", 6'h04);
    rd("R10 rxctl", 6'h08);
    // R3 peek vs pop
    rx(8'h41); rx(8'h42); rx(8'h43);
    rd("R3 peek", 6'h24);
    rd("R3 peek again", 6'h24);
    rd("R3 pop", 6'h20);
    rd("R3 pop", 6'h20);
    rd("R2 status", 6'h24);
    // R8/R9 rx interrupt
    wr("R9", 6'h2C, 32'h0000_0008);
    rd("R9 masked", 6'h38);
    wr("R8 ack rx", 6'h30, 32'h0000_0008);
    rd("R8 raw", 6'h34);
    wr("R8 raw write", 6'h34, 32'h0000_0000);
    rd("R8 raw", 6'h34);
    rd("R3 pop last", 6'h20);
    rd("R8 raw empty", 6'h34);
    // R4 fill beyond depth
    for (int i = 0; i < 18; i++) rx(8'h80 + 8'(i));
    rd("R4 full peek", 6'h24);
    for (int i = 0; i < 17; i++) rd("R4 drain order", 6'h20);
    // R11 push and pop together
    rx(8'hA1); rx(8'hA2);
    cyc("R11 pop+push", 1, 0, 6'h20, 0, 1, 8'hA3);
    rd("R11 order", 6'h20);
    rd("R11 order", 6'h20);
    rd("R11 empty", 6'h24);
    // R6/R7 transmit and acknowledge protection
    wr("R9 mask tx", 6'h2C, 32'h0000_0003);
    wr("R6", 6'h1C, 32'h1234_56A5);
    rd("R6 dout", 6'h1C);
    rd("R6 raw", 6'h34);
    wr("R7 ack protected", 6'h30, 32'h0000_0003);
    rd("R7 ack readback", 6'h30);
    rd("R7 raw", 6'h34);
    wr("R7 ack again", 6'h30, 32'h0000_0001);
    rd("R7 raw cleared", 6'h34);
    rd("R9 masked", 6'h38);
    // R10 ignored writes and unmapped/misaligned accesses
    wr("R10 ro", 6'h38, 32'hFFFF_FFFF);
    wr("R10 ro", 6'h24, 32'hFFFF_FFFF);
    wr("R10 misaligned", 6'h0A, 32'h0);
    rd("R10 rxctl kept", 6'h08);
    rd("R10 unmapped", 6'h10);
    rd("R10 misaligned", 6'h09);
    wr("R10 raw write", 6'h34, 32'h0000_0104);
    rd("R10 raw", 6'h34);
    // R5 disable again
    wr("R5", 6'h08, 32'h0);
    rx(8'h55);
    rd("R5 dropped", 6'h24);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule